// File: doc/BRIEF.md
# Framebuffer Layer Line Fetcher

This block is the memory-facing front end of one graphics layer. Once enabled, it walks a linear framebuffer line by line and issues byte addresses of 32-bit words through a valid/ready request port. Words returned by the memory side arrive in request order. Each returned word is split into 8-bit red, green, blue and alpha values and presented to the pixel pipeline with a valid flag.

The frame origin is a 64-bit address supplied as two 32-bit halves. The distance in bytes from one line start to the next comes from a separate stride value, so lines may be padded beyond width times four. A format code selects the byte order of each pixel word. Configuration is sampled when the layer is enabled. Software must keep the layer disabled while it changes the pointer or format. Dropping the enable aborts the frame at once. Raising it again restarts the walk from line 0.

Top module: `fb_line_fetch`

## Requirements
- R1: While reset is asserted and after its release, req_valid_o, pix_valid_o, frame_done_o and fmt_err_o are low.
- R2: The cycle after enable_i rises, the first request is presented at {base_hi_i, base_lo_i} with its two low bits forced to zero.
- R3: Within a line, successive requests step by 4 bytes. Line n starts at base + n*stride, where stride is stride_i with its two low bits forced to zero. The stride is independent of the width, which is in_size_i[15:0]; the height is in_size_i[31:16].
- R4: A request that is not accepted keeps req_valid_o high and req_addr_o unchanged until it is accepted or enable_i falls.
- R5: After width*height requests have been accepted, no further request is raised until enable_i falls and rises again.
- R6: Format 0x10 maps data byte 0 to blue, byte 1 to green and byte 2 to red, and reports alpha 0xFF. Format 0x11 maps byte 0 to red, byte 1 to green and byte 2 to blue, and reports alpha 0xFF.
- R7: Formats 0x08 and 0x09 order the colour bytes like 0x10 and 0x11 respectively, and report byte 3 as alpha.
- R8: Each response accepted while a frame is running gives a pixel on the pix outputs one cycle later.
- R9: Any other format code gives pixels with all components zero. It also sets fmt_err_o whenever the layer is enabled, and fmt_err_o stays set until reset.
- R10: While enable_i is low, req_valid_o is low in the same cycle. Responses are ignored, and pix_valid_o is low from the next cycle.
- R11: frame_done_o pulses for exactly one cycle, together with the pixel of the last column of the last line.
- R12: A width or height of zero produces no requests and no pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Layer enable; a rising edge starts a frame |
| base_lo_i | input | 32 | Frame origin, bits 31:0 |
| base_hi_i | input | 32 | Frame origin, bits 63:32 |
| stride_i | input | 32 | Bytes between line starts |
| in_size_i | input | 32 | Width in bits 15:0, height in bits 31:16 |
| fmt_i | input | 8 | Pixel format code |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 64 | Byte address of the requested word |
| rsp_valid_i | input | 1 | Returned word valid |
| rsp_data_i | input | 32 | Returned word |
| pix_valid_o | output | 1 | Pixel valid |
| pix_r_o | output | 8 | Red |
| pix_g_o | output | 8 | Green |
| pix_b_o | output | 8 | Blue |
| pix_a_o | output | 8 | Alpha |
| frame_done_o | output | 1 | Last pixel of the frame |
| fmt_err_o | output | 1 | Sticky unsupported-format flag |

## Verification
The first frame uses a base above 4 GiB, a stride equal to width*4, a ready that is always high and a response every cycle. This separates the use of the high base word from the stepping within a line. A second frame pads the stride well beyond the line and throttles both ready and responses. A wrong line step or lost backpressure then appears as an address mismatch, and a miscounted column appears as a misplaced done pulse. Each of the four supported format codes, and one unsupported code, is run against word data whose four bytes all differ, so any swapped byte or wrong alpha source is caught. Further runs cover an abort in mid-frame with responses driven while disabled, and a zero-height frame.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;

  typedef enum logic [7:0] {
    FMT_ARGB = 8'h08,
    FMT_ABGR = 8'h09,
    FMT_XRGB = 8'h10,
    FMT_XBGR = 8'h11
  } fb_fmt_e;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pix_t;

  function automatic logic fmt_ok(logic [7:0] f);
    return (f == FMT_ARGB) || (f == FMT_ABGR) || (f == FMT_XRGB) || (f == FMT_XBGR);
  endfunction

  function automatic pix_t unpack(logic [7:0] f, logic [31:0] d);
    pix_t p;
    p = '0;
    case (f)
      FMT_XRGB, FMT_ARGB: begin
        p.b = d[7:0];  p.g = d[15:8]; p.r = d[23:16];
      end
      FMT_XBGR, FMT_ABGR: begin
        p.r = d[7:0];  p.g = d[15:8]; p.b = d[23:16];
      end
      default: p = '0;
    endcase
    if (f == FMT_ARGB || f == FMT_ABGR) p.a = d[31:24];
    else if (f == FMT_XRGB || f == FMT_XBGR) p.a = 8'hFF;
    return p;
  endfunction

endpackage

// File: rtl/fb_req_gen.sv
module fb_req_gen #(
  parameter int ADDR_W   = 64,
  parameter int STRIDE_W = 32,
  parameter int DIM_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  localparam logic [ADDR_W-1:0]   WORD_BYTES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0]   ADDR_MASK  = ~ADDR_W'(3);
  localparam logic [STRIDE_W-1:0] STR_MASK   = ~STRIDE_W'(3);

  logic              busy_q;
  logic [DIM_W-1:0]  x_q, y_q, w_q, h_q;
  logic [ADDR_W-1:0] line_q, addr_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [ADDR_W-1:0] next_line;

  assign next_line = line_q + ADDR_W'(stride_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= '0;
      h_q      <= '0;
      line_q   <= '0;
      addr_q   <= '0;
      stride_q <= '0;
    end else if (!enable_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      line_q   <= base_i & ADDR_MASK;
      addr_q   <= base_i & ADDR_MASK;
      stride_q <= stride_i & STR_MASK;
      w_q      <= width_i;
      h_q      <= height_i;
      x_q      <= '0;
      y_q      <= '0;
      busy_q   <= (width_i != '0) && (height_i != '0);
    end else if (busy_q && req_ready_i) begin
      if (x_q == w_q - 1'b1) begin
        x_q    <= '0;
        line_q <= next_line;
        addr_q <= next_line;
        if (y_q == h_q - 1'b1) busy_q <= 1'b0;
        else                   y_q    <= y_q + 1'b1;
      end else begin
        x_q    <= x_q + 1'b1;
        addr_q <= addr_q + WORD_BYTES;
      end
    end
  end

  assign req_valid_o = busy_q && enable_i;
  assign req_addr_o  = addr_q;
endmodule

// File: rtl/fb_unpack.sv
module fb_unpack
  import fb_fetch_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [7:0]        fmt_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              pix_valid_o,
  output pix_t              pix_o,
  output logic              frame_done_o
);
  logic             active_q;
  logic [DIM_W-1:0] px_q, py_q, w_q, h_q;
  logic             acc, col_last, row_last;

  assign acc      = active_q && enable_i && rsp_valid_i;
  assign col_last = (px_q == w_q - 1'b1);
  assign row_last = (py_q == h_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      px_q         <= '0;
      py_q         <= '0;
      w_q          <= '0;
      h_q          <= '0;
      pix_valid_o  <= 1'b0;
      pix_o        <= '0;
      frame_done_o <= 1'b0;
    end else begin
      pix_valid_o  <= acc;
      frame_done_o <= acc && col_last && row_last;
      if (acc) pix_o <= unpack(fmt_i, rsp_data_i[31:0]);
      if (!enable_i) begin
        active_q <= 1'b0;
      end else if (start_i) begin
        active_q <= (width_i != '0) && (height_i != '0);
        w_q      <= width_i;
        h_q      <= height_i;
        px_q     <= '0;
        py_q     <= '0;
      end else if (acc) begin
        if (col_last) begin
          px_q <= '0;
          py_q <= py_q + 1'b1;
          if (row_last) active_q <= 1'b0;
        end else begin
          px_q <= px_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch
  import fb_fetch_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [REG_W-1:0] base_lo_i,
  input  logic [REG_W-1:0] base_hi_i,
  input  logic [REG_W-1:0] stride_i,
  input  logic [REG_W-1:0] in_size_i,
  input  logic [7:0]       fmt_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [2*REG_W-1:0] req_addr_o,
  input  logic             rsp_valid_i,
  input  logic [REG_W-1:0] rsp_data_i,
  output logic             pix_valid_o,
  output logic [7:0]       pix_r_o,
  output logic [7:0]       pix_g_o,
  output logic [7:0]       pix_b_o,
  output logic [7:0]       pix_a_o,
  output logic             frame_done_o,
  output logic             fmt_err_o
);
  localparam int ADDR_W = 2 * REG_W;
  localparam int H_LSB  = REG_W / 2;

  logic             en_q, start;
  logic [DIM_W-1:0] width, height;
  pix_t             pix;

  assign start  = enable_i && !en_q;
  assign width  = in_size_i[DIM_W-1:0];
  assign height = in_size_i[H_LSB +: DIM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      fmt_err_o <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (enable_i && !fmt_ok(fmt_i)) fmt_err_o <= 1'b1;
    end
  end

  fb_req_gen #(.ADDR_W(ADDR_W), .STRIDE_W(REG_W), .DIM_W(DIM_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .start_i     (start),
    .base_i      ({base_hi_i, base_lo_i}),
    .stride_i    (stride_i),
    .width_i     (width),
    .height_i    (height),
    .req_ready_i (req_ready_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o)
  );

  fb_unpack #(.DIM_W(DIM_W), .DATA_W(REG_W)) u_unp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .start_i      (start),
    .width_i      (width),
    .height_i     (height),
    .fmt_i        (fmt_i),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_data_i   (rsp_data_i),
    .pix_valid_o  (pix_valid_o),
    .pix_o        (pix),
    .frame_done_o (frame_done_o)
  );

  assign pix_r_o = pix.r;
  assign pix_g_o = pix.g;
  assign pix_b_o = pix.b;
  assign pix_a_o = pix.a;
endmodule

// File: rtl/fb_line_fetch_chk.sv
module fb_line_fetch_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              pix_valid_o,
  input logic              frame_done_o,
  input logic              fmt_err_o
);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (!enable_i || (req_valid_o && $stable(req_addr_o))));

  p_off_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !req_valid_o);

  p_off_pix_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !pix_valid_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  p_done_pix_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> pix_valid_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> fmt_err_o);
endmodule

bind fb_line_fetch fb_line_fetch_chk #(.ADDR_W(2 * REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_addr_o   (req_addr_o),
  .pix_valid_o  (pix_valid_o),
  .frame_done_o (frame_done_o),
  .fmt_err_o    (fmt_err_o)
);

// File: tb/sim_fb_line_fetch.sv
`timescale 1ns/1ps
module sim_fb_line_fetch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [31:0] base_lo_i = '0, base_hi_i = '0, stride_i = '0, in_size_i = '0;
  logic [7:0]  fmt_i = 8'h10;
  logic        req_valid_o, req_ready_i = 1'b0;
  logic [63:0] req_addr_o;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic        pix_valid_o, frame_done_o, fmt_err_o;
  logic [7:0]  pix_r_o, pix_g_o, pix_b_o, pix_a_o;

  always #2.5 clk_i = ~clk_i;

  fb_line_fetch u0 (.*);

  int total = 0, bad = 0;
  bit en_cmd = 0, prev_en = 0, rsp_force = 0;
  int rmode = 0, smode = 0, cyc = 0;
  longint unsigned mbase, mstride;
  int mw = 0, mh = 0, mx = 0, my = 0, rsp_cnt = 0;
  bit mbusy = 0, done_flag = 0;
  longint unsigned rq[$];
  bit e_pv = 0, e_done = 0, e_err = 0;
  logic [7:0] e_r, e_g, e_b, e_a;

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] word_of(longint unsigned a);
    return a[31:0] * 32'h9E3779B1 ^ a[63:32] ^ 32'hC3A5_5A3C;
  endfunction

  // expected pixel by format code
  task automatic expect_pix(input logic [7:0] f, input logic [31:0] d);
    e_r = 0; e_g = 0; e_b = 0; e_a = 0;
    if (f == 8'h10 || f == 8'h08) begin e_b = d[7:0]; e_g = d[15:8]; e_r = d[23:16]; end
    if (f == 8'h11 || f == 8'h09) begin e_r = d[7:0]; e_g = d[15:8]; e_b = d[23:16]; end
    if (f == 8'h08 || f == 8'h09) e_a = d[31:24];
    if (f == 8'h10 || f == 8'h11) e_a = 8'hFF;
  endtask

  task automatic step();
    bit n_pv, n_done, exp_rv;
    longint unsigned ea;
    string tag;
    @(negedge clk_i);
    // outputs of the last edge
    chk(pix_valid_o == e_pv, "R8 pix_valid", pix_valid_o, e_pv);
    if (e_pv && pix_valid_o) begin
      tag = (fmt_i == 8'h08 || fmt_i == 8'h09) ? "R7" : ((fmt_i == 8'h10 || fmt_i == 8'h11) ? "R6" : "R9");
      chk({pix_r_o, pix_g_o, pix_b_o, pix_a_o} == {e_r, e_g, e_b, e_a}, {tag, " pixel rgba"},
          {pix_r_o, pix_g_o, pix_b_o, pix_a_o}, {e_r, e_g, e_b, e_a});
    end
    chk(frame_done_o == e_done, "R11 frame_done", frame_done_o, e_done);
    chk(fmt_err_o == e_err, "R9 fmt_err", fmt_err_o, e_err);
    // drive
    prev_en = enable_i;
    enable_i = en_cmd;
    cyc++;
    req_ready_i = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
    n_pv = 0; n_done = 0;
    if (enable_i && prev_en && rq.size() > 0 && (smode == 0 || (cyc % 2) == 0)) begin
      ea = rq.pop_front();
      rsp_valid_i = 1'b1;
      rsp_data_i = word_of(ea);
      expect_pix(fmt_i, rsp_data_i);
      rsp_cnt++;
      n_pv = 1;
      n_done = (rsp_cnt == mw * mh);
    end else if (rsp_force) begin
      rsp_valid_i = 1'b1;
      rsp_data_i = 32'hDEAD_BEEF;
    end else begin
      rsp_valid_i = 1'b0;
    end
    if (enable_i && !(fmt_i inside {8'h08, 8'h09, 8'h10, 8'h11})) e_err = 1;
    if (!enable_i) begin rq.delete(); mbusy = 0; end
    #1;
    exp_rv = mbusy && enable_i;
    tag = !enable_i ? "R10" : ((mw == 0 || mh == 0) ? "R12" : "R5");
    if (exp_rv) tag = "R3";
    chk(req_valid_o == exp_rv, {tag, " req_valid"}, req_valid_o, exp_rv);
    if (req_valid_o && exp_rv && req_ready_i) begin
      ea = mbase + longint'(my) * mstride + longint'(mx) * 4;
      chk(req_addr_o == ea, (mx == 0 && my == 0) ? "R2 first addr" : "R3 addr", req_addr_o, ea);
      rq.push_back(ea);
      if (mx == mw - 1) begin
        mx = 0;
        if (my == mh - 1) mbusy = 0; else my++;
      end else mx++;
    end
    if (enable_i && !prev_en) begin
      mbusy = (mw != 0 && mh != 0); mx = 0; my = 0; rsp_cnt = 0;
    end
    e_pv = n_pv; e_done = n_done;
  endtask

  task automatic run_frame(input longint unsigned base, input int unsigned stride, input int w, input int h,
                           input logic [7:0] fmt, input int rm, input int sm, input int on_cycles);
    base_lo_i = base[31:0]; base_hi_i = base[63:32];
    stride_i = stride; in_size_i = {h[15:0], w[15:0]}; fmt_i = fmt;
    mbase = base & ~64'h3; mstride = stride & ~32'h3; mw = w; mh = h;
    rmode = rm; smode = sm;
    en_cmd = 1;
    repeat (on_cycles) step();
    en_cmd = 0;
    repeat (3) step();
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 during and after reset
    repeat (3) @(negedge clk_i);
    chk({req_valid_o, pix_valid_o, frame_done_o, fmt_err_o} == 4'b0, "R1 reset outputs",
        {req_valid_o, pix_valid_o, frame_done_o, fmt_err_o}, 0);
    rst_ni = 1'b1;
    repeat (4) step();
    // R2/R3/R6: base above 4 GiB, packed stride, full throughput
    run_frame(64'h0000_0001_8000_0010, 16, 4, 3, 8'h10, 0, 0, 40);
    // R3/R4/R6: padded stride, throttled ready and responses
    run_frame(64'h0000_0002_0000_1003, 64, 5, 2, 8'h11, 1, 1, 80);
    // R7: alpha formats
    run_frame(64'h0000_0000_0000_4000, 12, 3, 2, 8'h08, 0, 1, 40);
    run_frame(64'h0000_0000_0000_5000, 20, 3, 2, 8'h09, 1, 0, 40);
    // R10: abort mid-frame, responses driven while disabled
    run_frame(64'h0000_0000_0001_0000, 32, 8, 4, 8'h10, 0, 0, 6);
    rsp_force = 1; repeat (4) step(); rsp_force = 0;
    // R5: restart after abort, then idle long after the last request
    run_frame(64'h0000_0000_0001_0000, 32, 2, 2, 8'h10, 0, 0, 30);
    // R12: zero height and zero width
    run_frame(64'h0000_0000_0002_0000, 16, 4, 0, 8'h10, 0, 0, 10);
    run_frame(64'h0000_0000_0002_0000, 16, 0, 3, 8'h11, 0, 0, 10);
    // R9: unsupported code, black pixels, sticky flag
    run_frame(64'h0000_0000_0003_0000, 8, 2, 1, 8'h33, 0, 0, 12);
    run_frame(64'h0000_0000_0003_0000, 8, 2, 1, 8'h10, 0, 0, 12);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule